// File: doc/BRIEF.md
# CPU Video Memory Access Port

This block sits between a host CPU on a 16-bit bus and the video memory of a display controller. The CPU never holds a memory address directly. It loads a 10-bit column register and a 10-bit row register, and the two registers together form a 20-bit pixel address, with the row in the upper half. Each data transfer moves one 16-bit word at that address. The transfer can then leave the address alone, move the column one to the right, or move the row one up or one down. With these steps the CPU sets a start position once and then streams a run of words along a line or down a column.

A CPU access is selected by a 6-bit operation code taken from bus address lines and framed by an access strobe. A data access takes the memory address and write path away from the display scan at once and holds them until the strobe ends. There is no arbitration and no wait signal, so the display shows a few wrong pixels during each access. When no data access is in progress, the scan address passes to the memory through one register stage.

Top module: `vram_cpu_port`

## Requirements
- R1: While `rst` is high and on the first edge after it, `cpu_sel`, `mem_we`, `cpu_rdata` and `mem_addr` are zero, and both the column and row registers are zero.
- R2: Code 0 loads the column register from `cpu_wdata[9:0]`; code 1 loads the row register from `cpu_wdata[9:0]`. The load takes effect when the access ends, and neither code touches memory.
- R3: On a data access (codes 2 to 5), from the first clock edge that samples `cpu_strobe` high up to the edge that first samples it low, `cpu_sel` is 1 and `mem_addr` holds {row, column} without change.
- R4: Outside a data access `cpu_sel` is 0, `mem_we` is 0 and `mem_addr` equals `scan_addr` as sampled on the previous clock edge.
- R5: During a data access with `cpu_we` = 1, `mem_we` is 1 and `mem_wdata` holds the `cpu_wdata` present at the start of the access. `mem_we` is never 1 while `cpu_sel` is 0.
- R6: A data access with `cpu_we` = 0 captures `mem_rdata` into `cpu_rdata` on the edge that ends the access. `cpu_rdata` holds its value at every other edge.
- R7: Code 3 adds one to the column register after the access. The column wraps from 1023 to 0 and the row does not change.
- R8: Code 4 adds one to the row register and code 5 subtracts one from it after the access. Both wrap modulo 1024 and leave the column unchanged.
- R9: Code 2 transfers data without stepping. Codes 6 to 63 change neither register, never raise `cpu_sel` and never affect memory.
- R10: A step always follows the transfer, so the word moved by a stepping access comes from, or goes to, the address before the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_strobe | input | 1 | High for the duration of one CPU access |
| cpu_op | input | 6 | Operation code from the bus address lines |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 16 | Write data, or register load value in bits 9:0 |
| cpu_rdata | output | 16 | Read data captured at the end of the access |
| scan_addr | input | 20 | Display scan address |
| mem_addr | output | 20 | Address to video memory |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| cpu_sel | output | 1 | 1 while the CPU owns the memory path |

## Verification
A wrong column or row value does not show until the next data access. It then appears on `mem_addr` one edge after the strobe rises, so each access sweep is followed by a non-stepping read. A step applied too early shows up as read data taken from the next address, and it is seen at the edge that ends the access. A path-select fault appears within one cycle as `mem_addr` disagreeing with the previous scan address, or as `mem_we` set while idle.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
  localparam int OP_W = 6;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_XINC = 2'd1,
    STEP_YINC = 2'd2,
    STEP_YDEC = 2'd3
  } step_e;

  typedef struct packed {
    logic  ld_x;
    logic  ld_y;
    logic  data;
    step_e step;
  } opdec_t;
endpackage

// File: rtl/vcp_decode.sv
module vcp_decode
  import vcp_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output opdec_t          dec
);
  always_comb begin
    dec = '{ld_x: 1'b0, ld_y: 1'b0, data: 1'b0, step: STEP_NONE};
    case (op)
      6'd0: dec.ld_x = 1'b1;
      6'd1: dec.ld_y = 1'b1;
      6'd2: dec.data = 1'b1;
      6'd3: begin dec.data = 1'b1; dec.step = STEP_XINC; end
      6'd4: begin dec.data = 1'b1; dec.step = STEP_YINC; end
      6'd5: begin dec.data = 1'b1; dec.step = STEP_YDEC; end
      default: ;
    endcase
  end
endmodule

// File: rtl/vcp_addr_regs.sv
module vcp_addr_regs
  import vcp_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  opdec_t        dec_q,
  input  logic [DW-1:0] wdata_q,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y
);
  localparam logic [XW-1:0] XONE = XW'(1);
  localparam logic [YW-1:0] YONE = YW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      x <= '0;
      y <= '0;
    end else if (commit) begin
      if (dec_q.ld_x) x <= wdata_q[XW-1:0];
      if (dec_q.ld_y) y <= wdata_q[YW-1:0];
      if (dec_q.data) begin
        case (dec_q.step)
          STEP_XINC: x <= x + XONE;
          STEP_YINC: y <= y + YONE;
          STEP_YDEC: y <= y - YONE;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vcp_path.sv
module vcp_path #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          begin_data,
  input  logic          end_acc,
  input  logic          we_live,
  input  logic [DW-1:0] wdata_live,
  input  logic          we_q,
  input  logic [AW-1:0] cpu_addr,
  input  logic [AW-1:0] scan_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          cpu_sel,
  output logic [DW-1:0] cpu_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      cpu_sel   <= 1'b0;
      cpu_rdata <= '0;
    end else if (begin_data) begin
      cpu_sel   <= 1'b1;
      mem_addr  <= cpu_addr;
      mem_we    <= we_live;
      mem_wdata <= wdata_live;
    end else if (cpu_sel && end_acc) begin
      cpu_sel  <= 1'b0;
      mem_we   <= 1'b0;
      mem_addr <= scan_addr;
      if (!we_q) cpu_rdata <= mem_rdata;
    end else if (!cpu_sel) begin
      mem_addr <= scan_addr;
    end
  end
endmodule

// File: rtl/vram_cpu_port.sv
module vram_cpu_port
  import vcp_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 10,
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_strobe,
  input  logic [OP_W-1:0]    cpu_op,
  input  logic               cpu_we,
  input  logic [DW-1:0]      cpu_wdata,
  output logic [DW-1:0]      cpu_rdata,
  input  logic [XW+YW-1:0]   scan_addr,
  output logic [XW+YW-1:0]   mem_addr,
  output logic               mem_we,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata,
  output logic               cpu_sel
);
  localparam int AW = XW + YW;

  logic          strobe_q;
  logic          start, stop;
  opdec_t        dec_live, dec_q;
  logic          we_q;
  logic [DW-1:0] wdata_q;
  logic [XW-1:0] x;
  logic [YW-1:0] y;

  assign start = cpu_strobe & ~strobe_q;
  assign stop  = ~cpu_strobe & strobe_q;

  vcp_decode u_dec (.op(cpu_op), .dec(dec_live));

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      dec_q    <= '{ld_x: 1'b0, ld_y: 1'b0, data: 1'b0, step: STEP_NONE};
      we_q     <= 1'b0;
      wdata_q  <= '0;
    end else begin
      strobe_q <= cpu_strobe;
      if (start) begin
        dec_q   <= dec_live;
        we_q    <= cpu_we;
        wdata_q <= cpu_wdata;
      end
    end
  end

  vcp_addr_regs #(.XW(XW), .YW(YW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .commit(stop), .dec_q(dec_q),
    .wdata_q(wdata_q), .x(x), .y(y)
  );

  vcp_path #(.AW(AW), .DW(DW)) u_path (
    .clk(clk), .rst(rst),
    .begin_data(start & dec_live.data), .end_acc(stop),
    .we_live(cpu_we), .wdata_live(cpu_wdata), .we_q(we_q),
    .cpu_addr({y, x}), .scan_addr(scan_addr), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .cpu_sel(cpu_sel), .cpu_rdata(cpu_rdata)
  );
endmodule

// File: rtl/vcp_checker.sv
module vcp_checker #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_strobe,
  input logic [AW-1:0] scan_addr,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          cpu_sel,
  input logic [DW-1:0] cpu_rdata
);
  // R1: the edge after reset leaves the memory path idle
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (!cpu_sel && !mem_we && cpu_rdata == '0));

  // R5: no write without CPU ownership
  p_we_owned_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> cpu_sel);

  // R3: address held steady while the CPU owns the path
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (cpu_sel && $past(cpu_sel)) |-> $stable(mem_addr));

  // R3: ownership only begins after the strobe was sampled high
  p_sel_from_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_sel) |-> $past(cpu_strobe));

  // R4: idle path carries the scan address one cycle late
  p_scan_follow_r4: assert property (@(posedge clk) disable iff (rst)
    (!cpu_sel && !$past(rst)) |-> mem_addr == $past(scan_addr));

  // R6: read data changes only when an access ends
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$fell(cpu_sel) |-> $stable(cpu_rdata));
endmodule

bind vram_cpu_port vcp_checker #(.AW(XW + YW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cpu_strobe(cpu_strobe), .scan_addr(scan_addr),
  .mem_addr(mem_addr), .mem_we(mem_we), .cpu_sel(cpu_sel),
  .cpu_rdata(cpu_rdata)
);

// File: tb/sim_vram_cpu_port.sv
module sim_vram_cpu_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_strobe = 1'b0;
  logic [5:0]  cpu_op = '0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic [19:0] scan_addr = '0;
  logic [19:0] mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        cpu_sel;

  int n_chk = 0;
  int n_err = 0;
  logic [9:0]  xm = '0, ym = '0;
  logic [15:0] rd_m = '0;

  always #2.5 clk = ~clk;

  // memory model: word content is a fixed function of the address
  function automatic logic [15:0] memf(logic [19:0] a);
    return a[15:0] ^ {12'h0, a[19:16]} ^ 16'hC3A5;
  endfunction
  assign mem_rdata = memf(mem_addr);

  vram_cpu_port u0 (
    .clk(clk), .rst(rst), .cpu_strobe(cpu_strobe), .cpu_op(cpu_op),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .scan_addr(scan_addr), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cpu_sel(cpu_sel)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(int op, bit we, logic [15:0] wd, int len);
    bit isdata;
    isdata = (op >= 2 && op <= 5);
    @(negedge clk);
    cpu_strobe = 1'b1; cpu_op = 6'(op); cpu_we = we; cpu_wdata = wd;
    @(negedge clk);
    if (isdata) begin
      chk("R3 sel", 32'(cpu_sel), 32'd1);
      chk("R3/R10 addr", 32'(mem_addr), 32'({ym, xm}));
      chk("R5 we", 32'(mem_we), 32'(we));
      if (we) chk("R5 wdata", 32'(mem_wdata), 32'(wd));
    end else begin
      chk("R9 no sel", 32'(cpu_sel), 32'd0);
      chk("R9 scan addr", 32'(mem_addr), 32'(scan_addr));
    end
    for (int i = 1; i < len; i++) @(negedge clk);
    if (isdata) chk("R3 addr held", 32'(mem_addr), 32'({ym, xm}));
    cpu_strobe = 1'b0; cpu_op = 6'h3F; cpu_wdata = 16'hFFFF;
    @(negedge clk);
    chk("R4 sel off", 32'(cpu_sel), 32'd0);
    chk("R4 we off", 32'(mem_we), 32'd0);
    chk("R4 scan", 32'(mem_addr), 32'(scan_addr));
    if (isdata && !we) rd_m = memf({ym, xm});
    chk("R6/R10 rdata", 32'(cpu_rdata), 32'(rd_m));
    case (op)
      0: xm = wd[9:0];
      1: ym = wd[9:0];
      3: xm = xm + 10'd1;
      4: ym = ym + 10'd1;
      5: ym = ym - 10'd1;
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sel", 32'(cpu_sel), 32'd0);
    chk("R1 we", 32'(mem_we), 32'd0);
    chk("R1 rdata", 32'(cpu_rdata), 32'd0);
    chk("R1 addr", 32'(mem_addr), 32'd0);
    rst = 1'b0;
    // R1: registers start at zero, seen by the first read
    acc(2, 0, 16'h0, 1);
    // R4: idle path follows scan address
    for (int i = 0; i < 16; i++) begin
      scan_addr = 20'(i * 65537 + 3);
      @(negedge clk);
      chk("R4 follow", 32'(mem_addr), 32'(scan_addr));
    end
    scan_addr = 20'h12345;
    // R2: register loads across several values
    for (int i = 0; i < 8; i++) begin
      acc(0, 1, 16'(i * 131 + 16'hFC00), 1);
      acc(1, 0, 16'(i * 97 + 5), 2);
      acc(2, 0, 16'h0, 1);
    end
    // R7: column burst across wrap
    acc(0, 1, 16'd1020, 1);
    acc(1, 1, 16'd7, 1);
    for (int i = 0; i < 6; i++) acc(3, 0, 16'h0, 1 + (i % 3));
    acc(2, 0, 16'h0, 1);
    // R8: row increment across wrap
    acc(1, 1, 16'd1021, 1);
    for (int i = 0; i < 5; i++) acc(4, 0, 16'h0, 1 + (i % 2));
    acc(2, 0, 16'h0, 1);
    // R8: row decrement across wrap
    acc(1, 1, 16'd2, 1);
    for (int i = 0; i < 5; i++) acc(5, 0, 16'h0, 2);
    acc(2, 0, 16'h0, 1);
    // R5: writes with each data code
    for (int op = 2; op <= 5; op++) acc(op, 1, 16'(op * 4369 + 1), 1 + op % 2);
    acc(2, 0, 16'h0, 1);
    // R9: all ignored codes, then verify nothing moved
    for (int op = 6; op < 64; op++) acc(op, op[0], 16'(op * 1000), 1);
    acc(2, 0, 16'h0, 1);
    acc(2, 0, 16'h0, 3);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule